// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is a purely combinational integer arithmetic-logic unit of parameterized width (16 bits by default). It accepts two operands and a 4-bit operation selector. It returns a result word and four status flags: zero, negative, carry and signed overflow. A surrounding datapath would latch the flags and use them to decide conditional branches.

Addition, subtraction and compare all use a single ripple-carry adder. For subtraction the second operand is inverted bit by bit and the adder's carry-in is raised, so the adder computes A + ~B + 1. Compare runs that same subtraction and updates the flags, but the result bus reads zero.

Logic operations clear the carry flag. The two one-bit shifts report the bit shifted out on the carry flag. The overflow flag is the true signed overflow of the adder, not a copy of its carry.

Top module: `alu_flagged`

## Requirements
- R1: Opcode 0 (ADD) gives result = (A + B) mod 2^W, with carry equal to the carry out of the top adder stage.
- R2: Opcode 1 (SUB) gives result = (A - B) mod 2^W, computed as A + ~B + 1 on the shared adder. Carry is 1 exactly when no borrow occurs, that is, when A >= B as unsigned numbers.
- R3: For ADD, SUB and CMP, overflow is 1 exactly when the signed mathematical result lies outside the W-bit two's-complement range. At W=16, 0x7FFF + 0x0001 gives 0x8000 with overflow 1.
- R4: Opcodes 2 (AND), 3 (OR), 4 (XOR) and 5 (NOT, result = ~A) give the bitwise result with carry 0 and overflow 0.
- R5: Opcode 6 (SHL) gives A shifted left by one with 0 entering at bit 0. Carry is the old bit W-1 of A, and overflow is 0.
- R6: Opcode 7 (SHR) gives A shifted right by one with 0 entering at bit W-1. Carry is the old bit 0 of A, and overflow is 0.
- R7: Opcode 8 (CMP) drives the result to 0 and sets zero, negative, carry and overflow exactly as SUB would for the same operands.
- R8: The zero flag is 1 exactly when every bit of the computed value is 0. For CMP the computed value is the internal difference.
- R9: The negative flag equals bit W-1 of the computed value. For CMP this is bit W-1 of the internal difference.
- R10: Opcodes 9 through 15 give result 0, zero flag 1, and negative, carry and overflow all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation selector (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 NOT, 6 SHL, 7 SHR, 8 CMP) |
| result | output | WIDTH | Operation result (0 for CMP and unused codes) |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / no-borrow / shifted-out bit |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Compare is the one operation where two functions meet in the same cycle: the subtraction that produces the flags, and the masking that forces the result bus to zero. When the operands differ, the flags must follow the hidden difference rather than the visible zero result.

The bench provokes this with CMP on equal operands, on a smaller first operand, and on a pair whose signed difference overflows. It judges each case by requiring result 0 together with the zero, negative, carry and overflow flags its own model predicts for the subtraction.

Carry-out and signed overflow can also rise together on one addition (0x8000 + 0x8000). That case is checked for both flags at once.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOT = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_CMP = 4'd8
  } alu_op_e;

  localparam logic [OPW-1:0] OP_LAST = 4'd8;

  // single-bit sum of a full adder
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // carry out of a full adder
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

  // signed overflow from the sign bits of both adder inputs and the sum
  function automatic logic signed_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

endpackage

// File: rtl/alu_ripple.sv
`timescale 1ns/1ps
module alu_ripple #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0]   chain;
  logic [W-1:0] b_eff;

  assign chain[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign b_eff[i]   = b[i] ^ sub;
    assign sum[i]     = alu_pkg::fa_sum(a[i], b_eff[i], chain[i]);
    assign chain[i+1] = alu_pkg::fa_carry(a[i], b_eff[i], chain[i]);
  end

  assign cout = chain[W];
  assign ovf  = alu_pkg::signed_ovf(a[W-1], b_eff[W-1], sum[W-1]);
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
  parameter int W = 16
) (
  input  logic [W-1:0]           a,
  input  logic [W-1:0]           b,
  input  logic [alu_pkg::OPW-1:0] op,
  output logic [W-1:0]           res
);
  import alu_pkg::*;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift1.sv
`timescale 1ns/1ps
module alu_shift1 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         right,
  output logic [W-1:0] res,
  output logic         spill
);
  logic [W-1:0] left_v;
  logic [W-1:0] right_v;

  assign left_v  = {a[W-2:0], 1'b0};
  assign right_v = {1'b0, a[W-1:1]};

  assign res   = right ? right_v : left_v;
  assign spill = right ? a[0] : a[W-1];
endmodule

// File: rtl/alu_flagged.sv
`timescale 1ns/1ps
module alu_flagged #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  // named internal events, visible to the checker
  logic             sub_ctl;
  logic             is_cmp;
  logic             op_valid;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] shift_res;
  logic             shift_out;
  logic [WIDTH-1:0] pre_res;
  logic             c_sel;
  logic             v_sel;

  assign sub_ctl  = (op_sel == OP_SUB) || (op_sel == OP_CMP);
  assign is_cmp   = (op_sel == OP_CMP);
  assign op_valid = (op_sel <= OP_LAST);

  alu_ripple #(.W(WIDTH)) u_add (
    .a    (op_a),
    .b    (op_b),
    .sub  (sub_ctl),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  alu_bitwise #(.W(WIDTH)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .op  (op_sel),
    .res (logic_res)
  );

  alu_shift1 #(.W(WIDTH)) u_shift (
    .a     (op_a),
    .right (op_sel == OP_SHR),
    .res   (shift_res),
    .spill (shift_out)
  );

  always_comb begin
    pre_res = '0;
    c_sel   = 1'b0;
    v_sel   = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB, OP_CMP: begin
        pre_res = add_sum;
        c_sel   = add_cout;
        v_sel   = add_ovf;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: pre_res = logic_res;
      OP_SHL, OP_SHR: begin
        pre_res = shift_res;
        c_sel   = shift_out;
      end
      default: ;
    endcase
  end

  assign flag_z = (pre_res == '0);
  assign flag_n = pre_res[MSB];
  assign flag_c = c_sel;
  assign flag_v = v_sel;
  assign result = is_cmp ? '0 : pre_res;
endmodule

// File: rtl/alu_flagged_chk.sv
`timescale 1ns/1ps
module alu_flagged_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c,
  input logic             flag_v,
  input logic             sub_ctl,
  input logic             is_cmp,
  input logic             op_valid,
  input logic [WIDTH-1:0] add_sum
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   wide_add;
  logic [WIDTH-1:0] diff;
  logic             is_add;
  logic             is_lgc;

  assign wide_add = {1'b0, op_a} + {1'b0, op_b};
  assign diff     = op_a - op_b;
  assign is_add   = (op_sel == 4'd0);
  assign is_lgc   = (op_sel >= 4'd2) && (op_sel <= 4'd5);

  always_comb begin
    // R1
    a_r1_add_sum: assert (!is_add || ({flag_c, result} == wide_add));
    // R2
    a_r2_sub_diff: assert (!sub_ctl || ((add_sum == diff) && (flag_c == (op_a >= op_b))));
    // R3
    a_r3_add_ovf: assert (!is_add ||
      (flag_v == ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB]))));
    // R4
    a_r4_logic_flags: assert (!is_lgc || (!flag_c && !flag_v));
    // R7
    a_r7_cmp_zero: assert (!is_cmp || (result == '0));
    // R8
    a_r8_zero_flag: assert (flag_z == (is_cmp ? (add_sum == '0) : (result == '0)));
    // R9
    a_r9_neg_flag: assert (flag_n == (is_cmp ? add_sum[MSB] : result[MSB]));
    // R10
    a_r10_unused: assert (op_valid ||
      ((result == '0) && flag_z && !flag_n && !flag_c && !flag_v));
  end
endmodule

bind alu_flagged alu_flagged_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .op_sel   (op_sel),
  .result   (result),
  .flag_z   (flag_z),
  .flag_n   (flag_n),
  .flag_c   (flag_c),
  .flag_v   (flag_v),
  .sub_ctl  (sub_ctl),
  .is_cmp   (is_cmp),
  .op_valid (op_valid),
  .add_sum  (add_sum)
);

// File: tb/sim_alu_flagged.sv
`timescale 1ns/1ps
module sim_alu_flagged;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] res;
    logic         z;
    logic         n;
    logic         c;
    logic         v;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   op_sel = 4'd0;
  logic [W-1:0] result;
  logic         flag_z, flag_n, flag_c, flag_v;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  alu_flagged #(.WIDTH(W)) u0 (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .result (result),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_c (flag_c),
    .flag_v (flag_v)
  );

  // independent reference model built from the requirements
  function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [3:0] op, input string tag);
    item_t e;
    int sa, sb, s;
    logic [W-1:0] val;
    sa = int'($signed(a));
    sb = int'($signed(b));
    val = '0;
    e.c = 1'b0;
    e.v = 1'b0;
    case (op)
      4'd0: begin
        val = a + b;
        e.c = (int'(a) + int'(b)) >= (1 << W);
        s = sa + sb;
        e.v = (s > 32767) || (s < -32768);
      end
      4'd1, 4'd8: begin
        val = a - b;
        e.c = (a >= b);
        s = sa - sb;
        e.v = (s > 32767) || (s < -32768);
      end
      4'd2: val = a & b;
      4'd3: val = a | b;
      4'd4: val = a ^ b;
      4'd5: val = ~a;
      4'd6: begin val = a << 1; e.c = a[W-1]; end
      4'd7: begin val = a >> 1; e.c = a[0]; end
      default: val = '0;
    endcase
    e.z   = (val == '0);
    e.n   = val[W-1];
    e.res = (op == 4'd8) ? '0 : val;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] op, input string tag);
    @(negedge clk);
    op_a   = a;
    op_b   = b;
    op_sel = op;
    exp_q.push_back(model(a, b, op, tag));
  endtask

  // monitor: compare on the rising edge, inputs change on the falling edge
  always @(posedge clk) begin
    item_t e;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      checks++;
      if (result !== e.res || flag_z !== e.z || flag_n !== e.n ||
          flag_c !== e.c || flag_v !== e.v) begin
        errors++;
        $display("FAIL %s: got res=%h z=%b n=%b c=%b v=%b, expected res=%h z=%b n=%b c=%b v=%b",
                 e.tag, result, flag_z, flag_n, flag_c, flag_v,
                 e.res, e.z, e.n, e.c, e.v);
      end
    end
  end

  initial begin
    // initial state: all-zero ADD
    drive(16'h0000, 16'h0000, 4'd0, "R8 initial zero");
    // R1 add
    drive(16'd42, 16'd58, 4'd0, "R1 add 42+58");
    drive(16'hFFFF, 16'h0001, 4'd0, "R1 add carry wrap");
    // R3 overflow
    drive(16'h7FFF, 16'h0001, 4'd0, "R3 add 7FFF+1");
    drive(16'h8000, 16'h8000, 4'd0, "R3 add carry and overflow");
    drive(16'h8000, 16'h0001, 4'd1, "R3 sub 8000-1");
    // R2 subtract
    drive(16'd100, 16'd58, 4'd1, "R2 sub 100-58");
    drive(16'h0000, 16'h0001, 4'd1, "R2 sub borrow");
    drive(16'h1234, 16'h1234, 4'd1, "R2 sub equal");
    // R4 logic
    drive(16'hCCCC, 16'hAAAA, 4'd2, "R4 and");
    drive(16'hCC00, 16'h0AAA, 4'd3, "R4 or");
    drive(16'hFFFF, 16'hFFFF, 4'd4, "R4 xor to zero");
    drive(16'h00FF, 16'h1234, 4'd5, "R4 not");
    // R5 / R6 shifts
    drive(16'd5, 16'h0000, 4'd6, "R5 shl 5");
    drive(16'h8001, 16'h0000, 4'd6, "R5 shl msb out");
    drive(16'h0003, 16'h0000, 4'd7, "R6 shr lsb out");
    drive(16'h8000, 16'h0000, 4'd7, "R6 shr zero fill");
    // R7 compare
    drive(16'h0042, 16'h0042, 4'd8, "R7 cmp equal");
    drive(16'd3, 16'd5, 4'd8, "R7 cmp less");
    drive(16'h7FFF, 16'hFFFF, 4'd8, "R7 cmp overflow");
    drive(16'h9000, 16'h0001, 4'd8, "R9 cmp negative diff");
    // R10 unused opcodes
    for (int k = 9; k < 16; k++) drive(16'hBEEF, 16'h1357, 4'(k), "R10 unused opcode");
    // mixed sweep over all operations
    for (int k = 0; k < 400; k++)
      drive(16'($urandom), 16'($urandom), 4'(k % 9), "R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule